// File: doc/BRIEF.md
# Serial Control Register Port

This block is a four-wire serial control port that sets up a bank of byte-wide configuration registers. A host lowers an active-low select, clocks bits in on a serial input on the rising edges of its own serial clock, and raises the select to commit the transfer. The serial clock has no fixed relation to the core clock. Each transfer opens with an instruction byte. That byte carries a power-control bit, so every command also sets the power state. A two-byte form writes or reads one register, and a single-byte form changes only the power state.

The register bank and the power state live in the serial-clock domain. A toggle synchronizer hands every committed update to the core clock domain, and the core side exposes a registered copy of the whole bank and of the power-down flag. One register bit drives a latch output in inverted form. Software sets that bit to 1, which drives the output low. An unexpected internal reset clears the bit, so the output returns high and flags the reset.

Top module: `mwc_ctl_port`

## Requirements
- R1: After reset, every register holds 0x00, the power state is power-down (`core_pwr_dn` = 1), `lo` = 1, `so_en` = 0, and the core-side copy shows the same values.
- R2: Serial input is sampled on rising `sclk` edges while `cs_n` is low, most significant bit first. The instruction byte is bit 7 = power bit, bits 6:3 = register address, bit 2 = read (1) / write (0), bit 1 = two-byte flag (1 = a data byte follows), bit 0 = don't care. The second byte is the data byte.
- R3: A two-byte write that has all 16 bits clocked in when `cs_n` rises loads the data byte into the addressed register.
- R4: A single-byte instruction (bit 1 = 0) changes only the power state. No register changes, even if further bits are clocked in.
- R5: Every committed instruction of at least 8 bits, reads included, sets the power state: power bit 0 selects power-up and 1 selects power-down. Registers keep their contents in both states and can be written in both.
- R6: A transfer that ends with fewer than 8 bits has no effect. A two-byte write that ends with 8 to 15 bits applies its power bit and leaves the registers unchanged.
- R7: `so_en` equals the inverse of `cs_n`. `so` is 0 during the instruction byte. In a two-byte read, `so` presents the addressed register MSB first, updated on falling `sclk` edges, with bit 7 appearing on the falling edge that follows the eighth rising edge.
- R8: `lo` is the inverse of bit 0 of register 1.
- R9: Within a few core cycles after a commit, `core_regs` and `core_pwr_dn` equal the committed values. They change at no other time.
- R10: Writes to addresses at or above `NUM_REGS` change nothing, and reads from those addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sclk | input | 1 | Serial clock, asynchronous to `clk` |
| cs_n | input | 1 | Active-low select; its rising edge commits the transfer |
| si | input | 1 | Serial data input |
| so | output | 1 | Serial data output |
| so_en | output | 1 | Output enable for `so` (high impedance when 0) |
| lo | output | 1 | Inverted latch output |
| core_regs | output | NUM_REGS*8 | Core-domain copy of the register bank, register i at bits [8i+7:8i] |
| core_pwr_dn | output | 1 | Core-domain power-down flag |

## Verification
The checks assume that commits are spaced far enough apart for each toggle to reach the core side before the next one. They also assume that `cs_n` changes only while `sclk` is low, and that no transfer clocks more than 16 bits. The bench keeps to these limits. It holds `sclk` low around both select edges, clocks at most 16 bits, and waits a dozen core cycles after every commit. Before each new transfer, the bench reads the core outputs and `lo` against a behavioural model of the register bank on every core clock.

// File: rtl/mwc_pkg.sv
package mwc_pkg;
  localparam int ADDR_W     = 4;
  localparam int DATA_W     = 8;
  localparam int FRAME_BITS = 2 * DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int IDX_W      = $clog2(DATA_W);

  // instruction byte without its don't-care bit 0
  typedef struct packed {
    logic              pwr_dn;
    logic [ADDR_W-1:0] addr;
    logic              rd;
    logic              two_byte;
  } instr_t;
endpackage

// File: rtl/mwc_shift.sv
module mwc_shift
  import mwc_pkg::*;
(
  input  logic                rst_n,
  input  logic                sclk,
  input  logic                cs_n,
  input  logic                si,
  input  logic [DATA_W-1:0]   rd_val,
  output logic [CNT_W-1:0]    cnt,
  output instr_t              instr,
  output logic [DATA_W-1:0]   data,
  output logic                so
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_BYTE = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_INST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sr_q, sr_d;
  instr_t            instr_q, instr_d;
  logic              so_q, so_d;
  logic              rd_phase;
  logic [IDX_W-1:0]  bit_sel;

  // rising-edge capture path
  always_comb begin
    cnt_d   = cnt_q;
    sr_d    = sr_q;
    instr_d = instr_q;
    if (cnt_q != CNT_FULL) begin
      cnt_d = cnt_q + 1'b1;
      sr_d  = {sr_q[DATA_W-2:0], si};
    end
    if (cnt_q == CNT_INST) begin
      instr_d = instr_t'(sr_q[DATA_W-2:0]);
    end
  end

  always_ff @(posedge sclk or posedge cs_n or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sr_q    <= '0;
      instr_q <= '0;
    end else if (cs_n) begin
      cnt_q   <= '0;
      sr_q    <= '0;
      instr_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      sr_q    <= sr_d;
      instr_q <= instr_d;
    end
  end

  // falling-edge launch path: data byte of a read, MSB first
  assign rd_phase = (cnt_q >= CNT_BYTE) && (cnt_q != CNT_FULL) &&
                    instr_q.rd && instr_q.two_byte;
  assign bit_sel  = IDX_W'(~cnt_q);

  always_comb begin
    so_d = 1'b0;
    if (rd_phase) begin
      so_d = rd_val[bit_sel];
    end
  end

  always_ff @(negedge sclk or posedge cs_n or negedge rst_n) begin
    if (!rst_n) begin
      so_q <= 1'b0;
    end else if (cs_n) begin
      so_q <= 1'b0;
    end else begin
      so_q <= so_d;
    end
  end

  assign cnt   = cnt_q;
  assign instr = instr_q;
  assign data  = sr_q;
  assign so    = so_q;
endmodule

// File: rtl/mwc_bank.sv
module mwc_bank
  import mwc_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int LO_REG   = 1,
  parameter int LO_BIT   = 0
) (
  input  logic                         rst_n,
  input  logic                         cs_n,
  input  logic [CNT_W-1:0]             cnt,
  input  instr_t                       instr,
  input  logic [DATA_W-1:0]            data,
  output logic [DATA_W-1:0]            rd_val,
  output logic [NUM_REGS*DATA_W-1:0]   bank,
  output logic                         pwr_dn,
  output logic                         upd_tgl,
  output logic                         lo
);
  logic byte_ok, wr_en;
  logic pd_q, pd_d, tgl_q, tgl_d;

  assign byte_ok = (cnt >= CNT_W'(DATA_W));
  assign wr_en   = byte_ok && instr.two_byte && !instr.rd &&
                   (cnt == CNT_W'(FRAME_BITS));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] q, d;
    always_comb begin
      d = q;
      if (wr_en && (instr.addr == ADDR_W'(i))) begin
        d = data;
      end
    end
    always_ff @(posedge cs_n or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else begin
        q <= d;
      end
    end
    assign bank[i*DATA_W +: DATA_W] = q;
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (instr.addr == ADDR_W'(i)) begin
        rd_val = bank[i*DATA_W +: DATA_W];
      end
    end
  end

  always_comb begin
    pd_d  = pd_q;
    tgl_d = tgl_q;
    if (byte_ok) begin
      pd_d  = instr.pwr_dn;
      tgl_d = ~tgl_q;
    end
  end

  always_ff @(posedge cs_n or negedge rst_n) begin
    if (!rst_n) begin
      pd_q  <= 1'b1;
      tgl_q <= 1'b0;
    end else begin
      pd_q  <= pd_d;
      tgl_q <= tgl_d;
    end
  end

  assign pwr_dn  = pd_q;
  assign upd_tgl = tgl_q;
  assign lo      = ~bank[LO_REG*DATA_W + LO_BIT];
endmodule

// File: rtl/mwc_sync.sv
module mwc_sync
  import mwc_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        upd_tgl,
  input  logic [NUM_REGS*DATA_W-1:0]  bank_in,
  input  logic                        pd_in,
  output logic [NUM_REGS*DATA_W-1:0]  bank_out,
  output logic                        pd_out,
  output logic                        tgl_seen,
  output logic                        cap
);
  logic [1:0]                       rst_sq;
  logic                             rst_core_n;
  logic [SYNC_STAGES-1:0]           tgl_sq;
  logic                             seen_q, seen_d;
  logic [NUM_REGS*DATA_W-1:0]       bank_q, bank_d;
  logic                             pd_q, pd_d;

  // reset: asserted asynchronously, released on clk
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sq <= '0;
    end else begin
      rst_sq <= {rst_sq[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sq[1];

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      tgl_sq <= '0;
    end else begin
      tgl_sq <= {tgl_sq[SYNC_STAGES-2:0], upd_tgl};
    end
  end

  assign cap = tgl_sq[SYNC_STAGES-1] ^ seen_q;

  always_comb begin
    seen_d = seen_q;
    bank_d = bank_q;
    pd_d   = pd_q;
    if (cap) begin
      seen_d = tgl_sq[SYNC_STAGES-1];
      bank_d = bank_in;
      pd_d   = pd_in;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      seen_q <= 1'b0;
      bank_q <= '0;
      pd_q   <= 1'b1;
    end else begin
      seen_q <= seen_d;
      bank_q <= bank_d;
      pd_q   <= pd_d;
    end
  end

  assign bank_out = bank_q;
  assign pd_out   = pd_q;
  assign tgl_seen = seen_q;
endmodule

// File: rtl/mwc_ctl_port.sv
module mwc_ctl_port
  import mwc_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int LO_REG      = 1,
  parameter int LO_BIT      = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sclk,
  input  logic                        cs_n,
  input  logic                        si,
  output logic                        so,
  output logic                        so_en,
  output logic                        lo,
  output logic [NUM_REGS*DATA_W-1:0]  core_regs,
  output logic                        core_pwr_dn
);
  logic [CNT_W-1:0]            shift_cnt;
  instr_t                      shift_instr;
  logic [DATA_W-1:0]           shift_data;
  logic [DATA_W-1:0]           rd_val;
  logic [NUM_REGS*DATA_W-1:0]  bank;
  logic                        pd;
  logic                        upd_tgl;
  logic                        tgl_seen;
  logic                        cap;

  mwc_shift u_shift (
    .rst_n  (rst_n),
    .sclk   (sclk),
    .cs_n   (cs_n),
    .si     (si),
    .rd_val (rd_val),
    .cnt    (shift_cnt),
    .instr  (shift_instr),
    .data   (shift_data),
    .so     (so)
  );

  mwc_bank #(
    .NUM_REGS (NUM_REGS),
    .LO_REG   (LO_REG),
    .LO_BIT   (LO_BIT)
  ) u_bank (
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .cnt     (shift_cnt),
    .instr   (shift_instr),
    .data    (shift_data),
    .rd_val  (rd_val),
    .bank    (bank),
    .pwr_dn  (pd),
    .upd_tgl (upd_tgl),
    .lo      (lo)
  );

  mwc_sync #(
    .NUM_REGS    (NUM_REGS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_tgl  (upd_tgl),
    .bank_in  (bank),
    .pd_in    (pd),
    .bank_out (core_regs),
    .pd_out   (core_pwr_dn),
    .tgl_seen (tgl_seen),
    .cap      (cap)
  );

  assign so_en = ~cs_n;
endmodule

// File: rtl/mwc_ctl_port_chk.sv
module mwc_ctl_port_chk
  import mwc_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int LO_REG   = 1,
  parameter int LO_BIT   = 0
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        sclk,
  input logic                        cs_n,
  input logic                        so,
  input logic                        lo,
  input logic [NUM_REGS*DATA_W-1:0]  core_regs,
  input logic                        core_pwr_dn,
  input logic [CNT_W-1:0]            cnt,
  input logic                        tgl,
  input logic                        tgl_seen,
  input logic                        cap,
  input logic [NUM_REGS*DATA_W-1:0]  bank,
  input logic                        pd
);
  assert_reset_state_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (core_pwr_dn && lo));

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> ($stable(core_regs) && $stable(core_pwr_dn)));

  assert_cfg_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> ((core_regs == $past(bank)) && (core_pwr_dn == $past(pd))));

  assert_co_quiet_R7: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    (cnt < CNT_W'(DATA_W)) |-> !so);

  assert_lo_track_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((tgl == tgl_seen) && !cap) |-> (lo == !core_regs[LO_REG*DATA_W + LO_BIT]));
endmodule

bind mwc_ctl_port mwc_ctl_port_chk #(
  .NUM_REGS (NUM_REGS),
  .LO_REG   (LO_REG),
  .LO_BIT   (LO_BIT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sclk        (sclk),
  .cs_n        (cs_n),
  .so          (so),
  .lo          (lo),
  .core_regs   (core_regs),
  .core_pwr_dn (core_pwr_dn),
  .cnt         (shift_cnt),
  .tgl         (upd_tgl),
  .tgl_seen    (tgl_seen),
  .cap         (cap),
  .bank        (bank),
  .pd          (pd)
);

// File: tb/mwc_ctl_port_tb.sv
module mwc_ctl_port_tb;
  localparam int NR = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic si = 1'b0;
  wire  so, so_en, lo, core_pwr_dn;
  wire  [NR*8-1:0] core_regs;

  always #2 clk = ~clk;

  mwc_ctl_port #(.NUM_REGS(NR)) u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .si(si),
    .so(so), .so_en(so_en), .lo(lo),
    .core_regs(core_regs), .core_pwr_dn(core_pwr_dn)
  );

  int checks = 0;
  int fails  = 0;
  logic [7:0] m_regs [16];
  logic       m_pd;
  bit         settled = 0;

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model once the core side has settled (R9, R8)
  always @(negedge clk) begin
    if (settled) begin
      for (int i = 0; i < NR; i++)
        chk(core_regs[i*8 +: 8] === m_regs[i], "R9 core_regs", core_regs[i*8 +: 8], m_regs[i]);
      chk(core_pwr_dn === m_pd, "R9 core_pwr_dn", core_pwr_dn, m_pd);
      chk(lo === ~m_regs[1][0], "R8 lo", lo, ~m_regs[1][0]);
    end
  end

  function automatic logic [7:0] ins(input bit p, input int a, input bit rd, input bit two);
    return {p, 4'(a), rd, two, 1'b0};
  endfunction

  task automatic xfer(input logic [15:0] bits, input int n,
                      output logic [7:0] rd, output bit quiet);
    logic [7:0] ib;
    int a;
    rd = '0; quiet = 1;
    settled = 0;
    @(negedge clk); #1;
    cs_n = 1'b0; #5;
    chk(so_en === 1'b1, "R7 so_en low-select", so_en, 1);
    for (int i = 0; i < n; i++) begin
      si = bits[15-i];
      #10 sclk = 1'b1;
      #10 sclk = 1'b0;
      #3;
      if (i >= 7 && i <= 14) rd[14-i] = so;
      else if (i < 7 && so !== 1'b0) quiet = 0;
      #7;
    end
    #5 cs_n = 1'b1;
    #3 chk(so_en === 1'b0, "R7 so_en idle", so_en, 0);
    // model update
    ib = bits[15:8];
    a  = int'(ib[6:3]);
    if (n >= 8) begin
      m_pd = ib[7];
      if (ib[1] && !ib[2] && n >= 16 && a < NR) m_regs[a] = bits[7:0];
    end
    repeat (12) @(posedge clk);
    settled = 1;
  endtask

  function automatic logic [7:0] exp_rd(input int a);
    return (a < NR) ? m_regs[a] : 8'h00;
  endfunction

  task automatic wr(input bit p, input int a, input logic [7:0] d);
    logic [7:0] r; bit q;
    xfer({ins(p, a, 0, 1), d}, 16, r, q);
  endtask

  task automatic rd_chk(input bit p, input int a, input string req);
    logic [7:0] r; bit q;
    xfer({ins(p, a, 1, 1), 8'h00}, 16, r, q);
    chk(r === exp_rd(a), req, r, exp_rd(a));
    chk(q, "R7 so quiet in instruction byte", q, 1);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] r; bit q;
    for (int i = 0; i < 16; i++) m_regs[i] = 8'h00;
    m_pd = 1'b1;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(core_regs === '0, "R1 regs", core_regs, 0);
    chk(core_pwr_dn === 1'b1, "R1 pwr_dn", core_pwr_dn, 1);
    chk(lo === 1'b1, "R1 lo", lo, 1);
    chk(so_en === 1'b0, "R1 so_en", so_en, 0);
    settled = 1;

    // R3 write, R5 power-down kept, R7 read back with power-up
    wr(1, 2, 8'hA5);
    chk(core_pwr_dn === 1'b1, "R5 stays down", core_pwr_dn, 1);
    rd_chk(0, 2, "R7 read reg2");
    chk(core_pwr_dn === 1'b0, "R5 read powers up", core_pwr_dn, 0);

    // R8 latch output
    wr(0, 1, 8'h01);
    chk(lo === 1'b0, "R8 lo low", lo, 0);

    // R4 single-byte with extra bits: power only
    xfer({ins(1, 2, 0, 0), 8'hFF}, 16, r, q);
    chk(core_pwr_dn === 1'b1, "R4 power down", core_pwr_dn, 1);
    chk(core_regs[2*8 +: 8] === 8'hA5, "R4 reg2 untouched", core_regs[2*8 +: 8], 8'hA5);

    // R5 write while powered down
    wr(1, 3, 8'h3C);
    rd_chk(1, 3, "R5 write in power-down");

    // R6 short transfer discarded
    xfer({ins(0, 5, 0, 1), 8'h99}, 5, r, q);
    chk(core_pwr_dn === 1'b1, "R6 short no power change", core_pwr_dn, 1);
    // R6 partial write: power applies, register unchanged
    xfer({ins(0, 4, 0, 1), 8'h77}, 12, r, q);
    chk(core_pwr_dn === 1'b0, "R6 partial power-up", core_pwr_dn, 0);
    chk(core_regs[4*8 +: 8] === 8'h00, "R6 partial reg4", core_regs[4*8 +: 8], 0);

    // R10 out-of-range address
    wr(0, 9, 8'h55);
    chk(core_regs === {m_regs[7], m_regs[6], m_regs[5], m_regs[4],
                       m_regs[3], m_regs[2], m_regs[1], m_regs[0]},
        "R10 no write", core_regs, 0);
    rd_chk(0, 9, "R10 read zero");

    // R2 bit order across several patterns
    for (int i = 0; i < NR; i++) wr(i[0], i, 8'(i * 37 + 3));
    for (int i = 0; i < NR; i++) rd_chk(0, i, "R2 R3 readback");

    // R8 latch output returns high
    wr(0, 1, 8'h00);
    chk(lo === 1'b1, "R8 lo high", lo, 1);

    settled = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule